// File: doc/BRIEF.md
# Transmit Frame-Sync Source Selector

This block produces the internal transmit frame-synchronization strobe of a serial port and controls the frame-sync pad. Two mode inputs pick one of three sources. The first source is the pad itself, which is then an input. The second is a built-in periodic pulse generator. The third is a one-cycle pulse fired each time transmit data is copied from the holding register into the shift register. A polarity input sets how the active-high internal strobe maps to and from the pad level.

The periodic generator advances only on cycles where a generator clock-enable is high. Its repetition period is `period_cfg + 1` enable ticks. Its active width is `width_cfg + 1` enable ticks, counted from count zero. The bit-clock divider, the shift registers and the register bus sit outside the block. They appear here only as the tick and copy strobes and as static configuration inputs.

Top module: `fsync_tx_select`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the generator and the copy pulse are cleared. With `drive_int`=1 in either internal mode and no copy strobe during reset, `fsync` is 0.
- R2: When `drive_int`=0 (external source), `pad_oe` is 0 whatever the value of `gen_sel`.
- R3: When `drive_int`=0, `fsync` equals `pad_in` XOR `pad_inv` in the same cycle, with no register in the path.
- R4: When `drive_int`=1, `pad_oe` is 1 and `pad_out` equals `fsync` XOR `pad_inv`.
- R5: In copy mode (`drive_int`=1, `gen_sel`=0), a `copy_stb` high in cycle N makes `fsync` high in cycle N+1. `fsync` is high in copy mode only in the cycle after such a strobe.
- R6: In copy mode, strobes on consecutive cycles give `fsync` high on the same number of consecutive cycles.
- R7: A `copy_stb` seen while copy mode is not selected produces no pulse after a later switch into copy mode.
- R8: In generator mode (`drive_int`=1, `gen_sel`=1), the generator count runs 0 to `period_cfg` and then wraps, moving one step per tick. `fsync` is high in the ticks whose count is at most `width_cfg`, and it updates one cycle after each tick.
- R9: If `width_cfg` >= `period_cfg`, then after the first tick `fsync` stays high through every following count.
- R10: Whenever generator mode is not selected, the generator count and output are cleared. On reselection `fsync` is 0 until the next tick, which starts the pattern at count zero.
- R11: Without a tick, the generator output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_int | input | 1 | 0: frame sync taken from pad; 1: block drives frame sync |
| gen_sel | input | 1 | With drive_int=1: 1 selects periodic generator, 0 selects copy pulse |
| pad_inv | input | 1 | Pad polarity: 1 inverts between pad level and internal strobe |
| copy_stb | input | 1 | One-cycle strobe on each data-to-shift-register copy |
| gen_tick | input | 1 | Generator clock-enable |
| period_cfg | input | 12 | Generator period minus one, in ticks |
| width_cfg | input | 8 | Generator active width minus one, in ticks |
| pad_in | input | 1 | Level read from the frame-sync pad |
| fsync | output | 1 | Internal active-high transmit frame sync |
| pad_out | output | 1 | Level driven onto the pad |
| pad_oe | output | 1 | Pad output enable |

## Verification
Four kinds of corner case get dedicated tests. The first is the pattern after a generator is deselected and then reselected. A counter that kept its old count would start the new pattern partway through a period rather than with a full active window. The second is a width at or above the period. A strict comparison or a missed wrap would let the strobe drop for one tick each period. The third covers copy strobes that arrive back to back, or in another mode just before a switch into copy mode. A design that stretched, merged or latched pulses would show extra or missing high cycles. The fourth covers the polarity and pad direction in all three modes. A design that inverted in the wrong direction, or drove the pad in external mode, would show a wrong level on `fsync` or `pad_out`, or `pad_oe` high.

// File: rtl/fsync_tx_pkg.sv
package fsync_tx_pkg;

    typedef enum logic [1:0] {
        SRC_PAD  = 2'd0,
        SRC_GEN  = 2'd1,
        SRC_COPY = 2'd2
    } fs_src_e;

    typedef struct packed {
        logic oe;
        logic lvl;
    } pad_drive_t;

    function automatic fs_src_e pick_source(input logic drive_int, input logic gen_sel);
        if (!drive_int)   return SRC_PAD;
        else if (gen_sel) return SRC_GEN;
        else              return SRC_COPY;
    endfunction

    function automatic int unsigned wider(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsync_tx_gen.sv
module fsync_tx_gen
    import fsync_tx_pkg::*;
#(
    parameter int unsigned PER_W = 12,
    parameter int unsigned WID_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    input  logic [WID_W-1:0] width,
    output logic             pulse
);
    localparam int unsigned CNT_W = wider(PER_W, WID_W);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_x;
    logic [CNT_W-1:0] wid_x;
    logic             at_end;

    assign per_x  = CNT_W'(period);
    assign wid_x  = CNT_W'(width);
    assign at_end = (cnt >= per_x);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (tick) begin
            pulse <= (cnt <= wid_x);
            cnt   <= at_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fsync_tx_copy.sv
module fsync_tx_copy (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic stb,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= armed && stb;
    end
endmodule

// File: rtl/fsync_tx_padmap.sv
module fsync_tx_padmap
    import fsync_tx_pkg::*;
(
    input  fs_src_e    src,
    input  logic       inv,
    input  logic       pad_lvl,
    input  logic       gen_fs,
    input  logic       copy_fs,
    output logic       fs,
    output pad_drive_t drv
);
    always_comb begin
        unique case (src)
            SRC_GEN:  fs = gen_fs;
            SRC_COPY: fs = copy_fs;
            default:  fs = pad_lvl ^ inv;
        endcase
        drv.oe  = (src != SRC_PAD);
        drv.lvl = drv.oe ? (fs ^ inv) : 1'b0;
    end
endmodule

// File: rtl/fsync_tx_select.sv
module fsync_tx_select
    import fsync_tx_pkg::*;
#(
    parameter int unsigned PER_W = 12,
    parameter int unsigned WID_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drive_int,
    input  logic             gen_sel,
    input  logic             pad_inv,
    input  logic             copy_stb,
    input  logic             gen_tick,
    input  logic [PER_W-1:0] period_cfg,
    input  logic [WID_W-1:0] width_cfg,
    input  logic             pad_in,
    output logic             fsync,
    output logic             pad_out,
    output logic             pad_oe
);
    fs_src_e    src;
    logic       gen_fs;
    logic       copy_fs;
    pad_drive_t drv;

    assign src = pick_source(drive_int, gen_sel);

    fsync_tx_gen #(.PER_W(PER_W), .WID_W(WID_W)) i_gen (
        .clk    (clk),
        .rst    (rst),
        .run    (src == SRC_GEN),
        .tick   (gen_tick),
        .period (period_cfg),
        .width  (width_cfg),
        .pulse  (gen_fs)
    );

    fsync_tx_copy i_copy (
        .clk   (clk),
        .rst   (rst),
        .armed (src == SRC_COPY),
        .stb   (copy_stb),
        .pulse (copy_fs)
    );

    fsync_tx_padmap i_pad (
        .src     (src),
        .inv     (pad_inv),
        .pad_lvl (pad_in),
        .gen_fs  (gen_fs),
        .copy_fs (copy_fs),
        .fs      (fsync),
        .drv     (drv)
    );

    assign pad_out = drv.lvl;
    assign pad_oe  = drv.oe;
endmodule

// File: rtl/fsync_tx_select_chk.sv
module fsync_tx_select_chk (
    input logic clk,
    input logic rst,
    input logic drive_int,
    input logic gen_sel,
    input logic pad_inv,
    input logic copy_stb,
    input logic gen_tick,
    input logic pad_in,
    input logic fsync,
    input logic pad_out,
    input logic pad_oe
);
    logic copy_mode;
    logic gen_mode;
    assign copy_mode = drive_int && !gen_sel;
    assign gen_mode  = drive_int && gen_sel;

    a_r2_ext_no_drive: assert property (@(posedge clk) disable iff (rst)
        !drive_int |-> !pad_oe);

    a_r3_ext_pass: assert property (@(posedge clk) disable iff (rst)
        !drive_int |-> (fsync == (pad_in ^ pad_inv)));

    a_r4_pad_level: assert property (@(posedge clk) disable iff (rst)
        drive_int |-> (pad_oe && (pad_out == (fsync ^ pad_inv))));

    a_r5_copy_fires: assert property (@(posedge clk) disable iff (rst)
        (copy_mode && copy_stb) |=> (!copy_mode || fsync));

    a_r5_copy_only_after_stb: assert property (@(posedge clk) disable iff (rst)
        (copy_mode && fsync) |-> $past(copy_mode && copy_stb));

    a_r10_reselect_low: assert property (@(posedge clk) disable iff (rst)
        (gen_mode && !$past(gen_mode)) |-> !fsync);

    a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (gen_mode && $past(gen_mode) && !$past(gen_tick)) |-> $stable(fsync));
endmodule

bind fsync_tx_select fsync_tx_select_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .drive_int (drive_int),
    .gen_sel   (gen_sel),
    .pad_inv   (pad_inv),
    .copy_stb  (copy_stb),
    .gen_tick  (gen_tick),
    .pad_in    (pad_in),
    .fsync     (fsync),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/test_fsync_tx_select.sv
module test_fsync_tx_select;
    logic        clk = 1'b0;
    logic        rst;
    logic        drive_int, gen_sel, pad_inv, copy_stb, gen_tick, pad_in;
    logic [11:0] period_cfg;
    logic [7:0]  width_cfg;
    logic        fsync, pad_out, pad_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    fsync_tx_select i_fsync_tx_select (
        .clk(clk), .rst(rst), .drive_int(drive_int), .gen_sel(gen_sel),
        .pad_inv(pad_inv), .copy_stb(copy_stb), .gen_tick(gen_tick),
        .period_cfg(period_cfg), .width_cfg(width_cfg), .pad_in(pad_in),
        .fsync(fsync), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // advance one clock edge and land on the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; drive_int = 1'b1; gen_sel = 1'b1; gen_tick = 1'b1;
        copy_stb = 1'b0; pad_inv = 1'b0; pad_in = 1'b0;
        period_cfg = 12'd3; width_cfg = 8'd1;
        step(); step();
        check("R1 gen out in reset", fsync, 0);
        rst = 1'b0;
        #1 check("R1 gen out first cycle after reset", fsync, 0);
        gen_sel = 1'b0;
        #1 check("R1 copy out after reset", fsync, 0);
        drive_int = 1'b0; gen_sel = 1'b0;
        #1 check("R2 pad input after reset", pad_oe, 0);
        step();
    endtask

    task automatic t_external();
        drive_int = 1'b0;
        for (int k = 0; k < 8; k++) begin
            gen_sel = k[0]; pad_in = k[1]; pad_inv = k[2];
            #1;
            check("R2 pad_oe low in external mode", pad_oe, 0);
            check("R3 fsync follows pad with polarity", fsync, int'(k[1] ^ k[2]));
        end
        step();
    endtask

    task automatic t_copy();
        drive_int = 1'b1; gen_sel = 1'b0; pad_inv = 1'b1; copy_stb = 1'b0;
        step();
        copy_stb = 1'b1;
        #1 check("R5 no pulse in strobe cycle", fsync, 0);
        step();
        copy_stb = 1'b0;
        check("R5 pulse in cycle after strobe", fsync, 1);
        check("R4 pad_out inverted pulse", pad_out, 0);
        check("R4 pad_oe high in copy mode", pad_oe, 1);
        step();
        check("R5 pulse one cycle wide", fsync, 0);
        check("R4 pad_out idle inverted", pad_out, 1);
        copy_stb = 1'b1;
        step(); check("R6 back-to-back pulse 1", fsync, 1);
        step(); check("R6 back-to-back pulse 2", fsync, 1);
        step(); check("R6 back-to-back pulse 3", fsync, 1);
        copy_stb = 1'b0;
        step(); check("R6 pulses end after strobes", fsync, 0);
        // strobe while another mode is selected, then switch in
        gen_sel = 1'b1; gen_tick = 1'b0; copy_stb = 1'b1;
        step();
        gen_sel = 1'b0; copy_stb = 1'b0;
        #1 check("R7 no pulse from strobe in other mode", fsync, 0);
        step(); check("R7 still no pulse", fsync, 0);
        drive_int = 1'b0; copy_stb = 1'b1;
        step();
        drive_int = 1'b1; copy_stb = 1'b0;
        #1 check("R7 no pulse from strobe in external mode", fsync, 0);
        step();
    endtask

    task automatic t_gen_pattern();
        drive_int = 1'b1; gen_sel = 1'b1; pad_inv = 1'b0;
        period_cfg = 12'd3; width_cfg = 8'd1; gen_tick = 1'b1;
        for (int k = 0; k < 8; k++) begin
            step();
            check("R8 generator pattern P=3 W=1", fsync, (k % 4) <= 1 ? 1 : 0);
            check("R4 pad_out follows generator", pad_out, (k % 4) <= 1 ? 1 : 0);
        end
        // slower ticks: every third cycle, P=2 W=0
        gen_sel = 1'b0; step();
        gen_sel = 1'b1; period_cfg = 12'd2; width_cfg = 8'd0;
        for (int t = 0; t < 6; t++) begin
            gen_tick = 1'b1; step();
            check("R8 tick-paced level", fsync, (t % 3) == 0 ? 1 : 0);
            gen_tick = 1'b0;
            step(); check("R11 hold without tick a", fsync, (t % 3) == 0 ? 1 : 0);
            step(); check("R11 hold without tick b", fsync, (t % 3) == 0 ? 1 : 0);
        end
    endtask

    task automatic t_gen_full();
        gen_sel = 1'b0; step();
        gen_sel = 1'b1; period_cfg = 12'd2; width_cfg = 8'd5; gen_tick = 1'b1;
        for (int k = 0; k < 9; k++) begin
            step(); check("R9 width over period held high", fsync, 1);
        end
        width_cfg = 8'd2;
        for (int k = 0; k < 6; k++) begin
            step(); check("R9 width equal to period held high", fsync, 1);
        end
    endtask

    task automatic t_gen_reselect();
        gen_sel = 1'b0; step();
        gen_sel = 1'b1; period_cfg = 12'd3; width_cfg = 8'd1; gen_tick = 1'b1;
        step(); step(); step();
        check("R8 third tick low", fsync, 0);
        gen_sel = 1'b0; gen_tick = 1'b0;
        step();
        gen_sel = 1'b1;
        #1 check("R10 low on reselection", fsync, 0);
        step(); check("R10 low until tick", fsync, 0);
        gen_tick = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step(); check("R10 restart from count zero", fsync, k <= 1 ? 1 : 0);
        end
    endtask

    initial begin
        t_reset();
        t_external();
        t_copy();
        t_gen_pattern();
        t_gen_full();
        t_gen_reselect();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule